// File: doc/BRIEF.md
# Single-Wire Bus Slave Reset and Presence Generator

This block sits at the line end of a slave on a single-wire open-drain bus. The bus input first passes a two-flop synchronizer and a glitch filter. The block then times every low pulse in whole microseconds, using a prescaler of `TICK_DIV` clocks. When the line rises again, it decides whether the pulse was a bus reset. The block keeps a speed flag that selects regular or overdrive timing. The command layer above raises that flag with a one-cycle request.

After it accepts a reset, the block strobes a reset-detected output to the command layer for one clock. It then waits a fixed delay and drives the line low for a fixed presence width through an open-drain pull-down enable. The delay and width come from the speed that holds after the reset. While it waits and while it drives, the block does not measure the line. It also never takes its own presence pulse for a new reset. A long reset returns the slave to regular speed. A shorter reset that is still valid in overdrive leaves overdrive set.

Top module: `sw_reset_presence`

## Requirements
- R1: After reset the speed flag is regular (`od_mode_o`=0), the pull-down enable is off and the reset strobe is low.
- R2: At regular speed, a filtered low pulse of at least `RST_MIN_STD` µs (480) is accepted as a reset.
- R3: At overdrive speed, the acceptance threshold is `RST_MIN_OD` µs (48). A shorter low pulse is ignored.
- R4: An accepted reset whose low time is at least `OD_EXIT_US` µs (480) clears the speed flag. A shorter accepted reset (for example 80 µs) keeps overdrive.
- R5: Every accepted reset produces `rst_seen_o` high for exactly one clock, on the clock after the decision.
- R6: The presence pull-down starts `PD_DLY` µs after the strobe and lasts `PD_WID` µs. At regular speed these are 30 and 120 µs; at overdrive speed they are 3 and 12 µs. The speed used is the one that holds right after the reset.
- R7: A one-clock `od_req_i` sets the speed flag to overdrive (1). The flag then stays set until a reset clears it.
- R8: If `od_req_i` is high in the same clock in which a reset is accepted, the request is dropped.
- R9: A bus low shorter than one µs (`TICK_DIV` clocks) is filtered out and causes no reset or strobe.
- R10: Bus activity during the presence delay and the presence pulse is not measured. The line low caused by the block's own pull-down never counts as a reset.
- R11: The low time is counted in whole µs, rounded down. A low of 480 µs minus one clock at regular speed is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Raw level of the open-drain bus line |
| od_req_i | input | 1 | One-cycle request from the command layer to enter overdrive |
| line_pd_o | output | 1 | Open-drain pull-down enable (1 drives the line low) |
| rst_seen_o | output | 1 | One-cycle strobe: a bus reset was accepted |
| od_mode_o | output | 1 | Speed flag: 0 regular, 1 overdrive |

## Verification
The reset decision and the overdrive request can land in the same clock. The reset wants to clear or keep the speed flag, and the request wants to set it. The bench releases a long regular-speed reset and times `od_req_i` so that it is high exactly during the decision clock. The flag must stay regular. The behavioural model in the bench judges that clock, and so does a scenario check on `od_mode_o` afterwards.

// File: rtl/sw_rp_pkg.sv
package sw_rp_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_LOW   = 2'd1,
      PH_WAIT  = 2'd2,
      PH_DRIVE = 2'd3
   } phase_e;

   function automatic int unsigned max_of3(input int unsigned a,
                                           input int unsigned b,
                                           input int unsigned c);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      return m;
   endfunction

endpackage

// File: rtl/sw_rp_infilt.sv
module sw_rp_infilt #(
   parameter int unsigned STAGES   = 2,
   parameter int unsigned HOLD_CYC = 50
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic line_i,
   output logic level_o,
   output logic fall_o
);
   localparam int unsigned CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;

   logic [STAGES-1:0] sync_q;
   logic [CW-1:0]     hold_q;
   logic              level_q;
   logic              prev_q;

   for (genvar gi = 0; gi < STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) sync_q[gi] <= 1'b1;
            else         sync_q[gi] <= line_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) sync_q[gi] <= 1'b1;
            else         sync_q[gi] <= sync_q[gi-1];
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hold_q  <= '0;
         level_q <= 1'b1;
         prev_q  <= 1'b1;
      end else begin
         prev_q <= level_q;
         if (sync_q[STAGES-1] == level_q) begin
            hold_q <= '0;
         end else if (hold_q == CW'(HOLD_CYC - 1)) begin
            hold_q  <= '0;
            level_q <= sync_q[STAGES-1];
         end else begin
            hold_q <= hold_q + 1'b1;
         end
      end
   end

   assign level_o = level_q;
   assign fall_o  = prev_q & ~level_q;

endmodule

// File: rtl/sw_rp_usec.sv
module sw_rp_usec #(
   parameter int unsigned TICK_DIV = 50,
   parameter int unsigned US_W     = 9
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            restart_i,
   input  logic            pre_one_i,
   input  logic            run_i,
   output logic [US_W-1:0] us_o,
   output logic            tick_o
);
   localparam int unsigned PW = $clog2(TICK_DIV);

   logic [PW-1:0]   pre_q;
   logic [US_W-1:0] us_q;

   assign tick_o = run_i && (pre_q == PW'(TICK_DIV - 1));
   assign us_o   = us_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pre_q <= '0;
         us_q  <= '0;
      end else if (restart_i) begin
         pre_q <= pre_one_i ? PW'(1) : '0;
         us_q  <= '0;
      end else if (run_i) begin
         if (tick_o) begin
            pre_q <= '0;
            if (us_q != {US_W{1'b1}}) us_q <= us_q + 1'b1;
         end else begin
            pre_q <= pre_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/sw_rp_ctrl.sv
module sw_rp_ctrl
   import sw_rp_pkg::*;
#(
   parameter int unsigned US_W        = 9,
   parameter int unsigned RST_MIN_STD = 480,
   parameter int unsigned RST_MIN_OD  = 48,
   parameter int unsigned OD_EXIT_US  = 480,
   parameter int unsigned PD_DLY_STD  = 30,
   parameter int unsigned PD_DLY_OD   = 3,
   parameter int unsigned PD_WID_STD  = 120,
   parameter int unsigned PD_WID_OD   = 12
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            level_i,
   input  logic            fall_i,
   input  logic            od_req_i,
   input  logic [US_W-1:0] us_i,
   input  logic            tick_i,
   output logic            restart_o,
   output logic            pre_one_o,
   output logic            run_o,
   output logic            pd_o,
   output logic            det_o,
   output logic            od_o
);
   localparam logic [US_W-1:0] THR_STD  = US_W'(RST_MIN_STD);
   localparam logic [US_W-1:0] THR_OD   = US_W'(RST_MIN_OD);
   localparam logic [US_W-1:0] EXIT_LIM = US_W'(OD_EXIT_US);
   localparam logic [US_W-1:0] DLY_STD  = US_W'(PD_DLY_STD - 1);
   localparam logic [US_W-1:0] DLY_OD   = US_W'(PD_DLY_OD - 1);
   localparam logic [US_W-1:0] WID_STD  = US_W'(PD_WID_STD - 1);
   localparam logic [US_W-1:0] WID_OD   = US_W'(PD_WID_OD - 1);

   phase_e          state_q, state_d;
   logic            od_q, od_d;
   logic            pres_od_q;
   logic            det_q;
   logic            rst_ok;
   logic [US_W-1:0] thr;
   logic [US_W-1:0] dly_last;
   logic [US_W-1:0] wid_last;

   assign thr      = od_q      ? THR_OD : THR_STD;
   assign dly_last = pres_od_q ? DLY_OD : DLY_STD;
   assign wid_last = pres_od_q ? WID_OD : WID_STD;

   always_comb begin
      state_d   = state_q;
      od_d      = od_q;
      restart_o = 1'b0;
      pre_one_o = 1'b0;
      run_o     = 1'b0;
      rst_ok    = 1'b0;
      unique case (state_q)
         PH_IDLE: begin
            if (fall_i) begin
               state_d   = PH_LOW;
               restart_o = 1'b1;
               pre_one_o = 1'b1;
            end
         end
         PH_LOW: begin
            run_o = 1'b1;
            if (level_i) begin
               if (us_i >= thr) begin
                  rst_ok    = 1'b1;
                  restart_o = 1'b1;
                  state_d   = PH_WAIT;
               end else begin
                  state_d = PH_IDLE;
               end
            end
         end
         PH_WAIT: begin
            run_o = 1'b1;
            if (tick_i && (us_i == dly_last)) begin
               restart_o = 1'b1;
               state_d   = PH_DRIVE;
            end
         end
         PH_DRIVE: begin
            run_o = 1'b1;
            if (tick_i && (us_i == wid_last)) begin
               restart_o = 1'b1;
               state_d   = PH_IDLE;
            end
         end
         default: state_d = PH_IDLE;
      endcase
      if (rst_ok) begin
         od_d = (us_i >= EXIT_LIM) ? 1'b0 : od_q;
      end else if (od_req_i) begin
         od_d = 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q   <= PH_IDLE;
         od_q      <= 1'b0;
         pres_od_q <= 1'b0;
         det_q     <= 1'b0;
      end else begin
         state_q <= state_d;
         od_q    <= od_d;
         det_q   <= rst_ok;
         if (rst_ok) pres_od_q <= od_d;
      end
   end

   assign pd_o  = (state_q == PH_DRIVE);
   assign det_o = det_q;
   assign od_o  = od_q;

endmodule

// File: rtl/sw_reset_presence.sv
module sw_reset_presence
   import sw_rp_pkg::*;
#(
   parameter int unsigned TICK_DIV    = 50,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned GLITCH_CYC  = TICK_DIV,
   parameter int unsigned RST_MIN_STD = 480,
   parameter int unsigned RST_MIN_OD  = 48,
   parameter int unsigned OD_EXIT_US  = 480,
   parameter int unsigned PD_DLY_STD  = 30,
   parameter int unsigned PD_DLY_OD   = 3,
   parameter int unsigned PD_WID_STD  = 120,
   parameter int unsigned PD_WID_OD   = 12
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic line_i,
   input  logic od_req_i,
   output logic line_pd_o,
   output logic rst_seen_o,
   output logic od_mode_o
);
   localparam int unsigned MAX_US = max_of3(max_of3(RST_MIN_STD, RST_MIN_OD, OD_EXIT_US),
                                            max_of3(PD_DLY_STD, PD_DLY_OD, 1),
                                            max_of3(PD_WID_STD, PD_WID_OD, 1));
   localparam int unsigned US_W   = $clog2(MAX_US + 1);

   if (TICK_DIV < 2) begin : g_bad_tick
      $error("sw_reset_presence: TICK_DIV must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("sw_reset_presence: SYNC_STAGES must be at least 2");
   end
   if (GLITCH_CYC < 2) begin : g_bad_glitch
      $error("sw_reset_presence: GLITCH_CYC must be at least 2");
   end
   if (PD_DLY_STD < 1 || PD_DLY_OD < 1 || PD_WID_STD < 1 || PD_WID_OD < 1) begin : g_bad_pres
      $error("sw_reset_presence: presence delay and width must be nonzero");
   end
   if (RST_MIN_OD > RST_MIN_STD || RST_MIN_OD < 1) begin : g_bad_thr
      $error("sw_reset_presence: overdrive threshold must be 1..regular threshold");
   end

   logic            level;
   logic            fall;
   logic            restart;
   logic            pre_one;
   logic            run;
   logic            tick;
   logic [US_W-1:0] us_cnt;

   sw_rp_infilt #(
      .STAGES   (SYNC_STAGES),
      .HOLD_CYC (GLITCH_CYC)
   ) u_infilt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .line_i  (line_i),
      .level_o (level),
      .fall_o  (fall)
   );

   sw_rp_usec #(
      .TICK_DIV (TICK_DIV),
      .US_W     (US_W)
   ) u_usec (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .restart_i (restart),
      .pre_one_i (pre_one),
      .run_i     (run),
      .us_o      (us_cnt),
      .tick_o    (tick)
   );

   sw_rp_ctrl #(
      .US_W        (US_W),
      .RST_MIN_STD (RST_MIN_STD),
      .RST_MIN_OD  (RST_MIN_OD),
      .OD_EXIT_US  (OD_EXIT_US),
      .PD_DLY_STD  (PD_DLY_STD),
      .PD_DLY_OD   (PD_DLY_OD),
      .PD_WID_STD  (PD_WID_STD),
      .PD_WID_OD   (PD_WID_OD)
   ) u_ctrl (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .level_i   (level),
      .fall_i    (fall),
      .od_req_i  (od_req_i),
      .us_i      (us_cnt),
      .tick_i    (tick),
      .restart_o (restart),
      .pre_one_o (pre_one),
      .run_o     (run),
      .pd_o      (line_pd_o),
      .det_o     (rst_seen_o),
      .od_o      (od_mode_o)
   );

endmodule

// File: rtl/sw_rp_checker.sv
module sw_rp_checker (
   input logic clk_i,
   input logic rst_ni,
   input logic od_req_i,
   input logic pd_i,
   input logic det_i,
   input logic od_i
);

   assert_det_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      det_i |=> !det_i);

   assert_no_pd_at_det_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      det_i |-> !pd_i);

   assert_pd_waits_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      det_i |=> !pd_i);

   assert_pd_min_width_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pd_i) |=> pd_i);

   assert_od_exit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(od_i) |-> det_i);

   assert_od_enter_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(od_i) |-> $past(od_req_i));

   assert_req_dropped_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (det_i && !$past(od_i)) |-> !od_i);

endmodule

bind sw_reset_presence sw_rp_checker u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .od_req_i (od_req_i),
   .pd_i     (line_pd_o),
   .det_i    (rst_seen_o),
   .od_i     (od_mode_o)
);

// File: tb/sw_reset_presence_tb.sv
module sw_reset_presence_tb_top;
   localparam int T = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic master = 1'b1;
   logic od_req = 1'b0;
   logic line_pd, rst_seen, od_mode;
   logic line;

   assign line = master & ~line_pd;

   always #10 clk = ~clk;

   sw_reset_presence #(.TICK_DIV(T)) dut_i (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .line_i     (line),
      .od_req_i   (od_req),
      .line_pd_o  (line_pd),
      .rst_seen_o (rst_seen),
      .od_mode_o  (od_mode)
   );

   int errors = 0;
   int checks = 0;
   bit done = 0;
   string cur_req = "R1";

   // behavioural reference model
   bit ms1 = 1, ms2 = 1, mfilt = 1, mprev = 1;
   int mrun = 0, mph = 0, mcnt = 0;
   bit mod = 0, mdet = 0, mpd = 0, mpod = 0;

   always @(posedge clk) begin
      bit raw, nf, ndet, nod;
      int us, thr;
      if (!rst_n) begin
         ms1 = 1; ms2 = 1; mfilt = 1; mprev = 1; mrun = 0;
         mph = 0; mcnt = 0; mod = 0; mdet = 0; mpd = 0; mpod = 0;
      end else begin
         raw = master & ~mpd;
         nf = mfilt;
         if (ms2 == mfilt) mrun = 0;
         else if (mrun == T - 1) begin nf = ms2; mrun = 0; end
         else mrun++;
         ndet = 0;
         nod = mod;
         case (mph)
            0: if (!mfilt && mprev) begin mph = 1; mcnt = 1; end
            1: begin
               if (!mfilt) mcnt++;
               else begin
                  us = mcnt / T;
                  thr = mod ? 48 : 480;
                  if (us >= thr) begin
                     ndet = 1;
                     nod = (us >= 480) ? 1'b0 : mod;
                     mpod = nod;
                     mph = 2; mcnt = 0;
                  end else mph = 0;
               end
            end
            2: begin
               mcnt++;
               if (mcnt == (mpod ? 3 : 30) * T) begin mph = 3; mcnt = 0; end
            end
            default: begin
               mcnt++;
               if (mcnt == (mpod ? 12 : 120) * T) begin mph = 0; mcnt = 0; end
            end
         endcase
         if (!ndet && od_req) nod = 1;
         mprev = mfilt; mfilt = nf; ms2 = ms1; ms1 = raw;
         mdet = ndet; mod = nod; mpd = (mph == 3);
      end
   end

   // monitors
   int cyc = 0;
   int det_cnt = 0, pd_cnt = 0, det_cyc = 0, rise_cyc = 0, fall_cyc = 0;
   int det_double = 0;
   bit det_prev = 0, pd_prev = 0;

   always @(posedge clk) cyc++;

   always @(negedge clk) begin
      if (!done) begin
         checks += 3;
         if (line_pd !== mpd) begin
            errors++;
            $display("FAIL R6 [%s] cyc %0d line_pd_o actual=%0b expected=%0b", cur_req, cyc, line_pd, mpd);
         end
         if (rst_seen !== mdet) begin
            errors++;
            $display("FAIL R5 [%s] cyc %0d rst_seen_o actual=%0b expected=%0b", cur_req, cyc, rst_seen, mdet);
         end
         if (od_mode !== mod) begin
            errors++;
            $display("FAIL R7 [%s] cyc %0d od_mode_o actual=%0b expected=%0b", cur_req, cyc, od_mode, mod);
         end
         if (rst_seen) begin det_cnt++; det_cyc = cyc; end
         if (rst_seen && det_prev) det_double++;
         if (line_pd && !pd_prev) begin pd_cnt++; rise_cyc = cyc; end
         if (!line_pd && pd_prev) fall_cyc = cyc;
         det_prev = rst_seen;
         pd_prev = line_pd;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic low_pulse(input int n);
      @(negedge clk);
      master = 1'b0;
      repeat (n) @(negedge clk);
      master = 1'b1;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
      finish_run();
   end

   initial begin
      int d0, p0;
      idle(3);
      rst_n = 1'b1;
      idle(2);
      chk(od_mode == 0, "R1 od after reset", od_mode, 0);
      chk(line_pd == 0, "R1 pd after reset", line_pd, 0);
      chk(rst_seen == 0, "R1 strobe after reset", rst_seen, 0);

      cur_req = "R11";
      d0 = det_cnt;
      low_pulse(480 * T - 1);
      idle(100);
      chk(det_cnt == d0, "R11 one clock short of 480 us", det_cnt - d0, 0);

      cur_req = "R2";
      d0 = det_cnt;
      low_pulse(480 * T);
      idle(800);
      chk(det_cnt == d0 + 1, "R2 480 us accepted", det_cnt - d0, 1);
      chk(rise_cyc - det_cyc == 30 * T, "R6 regular delay", rise_cyc - det_cyc, 30 * T);
      chk(fall_cyc - rise_cyc == 120 * T, "R6 regular width", fall_cyc - rise_cyc, 120 * T);

      cur_req = "R9";
      d0 = det_cnt;
      low_pulse(T - 1);
      idle(20);
      low_pulse(10);
      idle(40);
      chk(det_cnt == d0, "R9 glitch and short low", det_cnt - d0, 0);

      cur_req = "R7";
      @(negedge clk); od_req = 1'b1;
      @(negedge clk); od_req = 1'b0;
      idle(2);
      chk(od_mode == 1, "R7 request enters overdrive", od_mode, 1);

      cur_req = "R3";
      d0 = det_cnt;
      low_pulse(48 * T - 1);
      idle(50);
      chk(det_cnt == d0, "R3 below 48 us ignored", det_cnt - d0, 0);
      low_pulse(48 * T);
      idle(150);
      chk(det_cnt == d0 + 1, "R3 48 us accepted", det_cnt - d0, 1);
      chk(od_mode == 1, "R4 short reset keeps overdrive", od_mode, 1);
      chk(rise_cyc - det_cyc == 3 * T, "R6 overdrive delay", rise_cyc - det_cyc, 3 * T);
      chk(fall_cyc - rise_cyc == 12 * T, "R6 overdrive width", fall_cyc - rise_cyc, 12 * T);

      cur_req = "R4";
      low_pulse(80 * T);
      idle(150);
      chk(od_mode == 1, "R4 80 us keeps overdrive", od_mode, 1);
      d0 = det_cnt;
      low_pulse(480 * T);
      idle(800);
      chk(det_cnt == d0 + 1, "R4 long reset accepted", det_cnt - d0, 1);
      chk(od_mode == 0, "R4 long reset leaves overdrive", od_mode, 0);
      chk(rise_cyc - det_cyc == 30 * T, "R6 regular delay after exit", rise_cyc - det_cyc, 30 * T);

      cur_req = "R8";
      d0 = det_cnt;
      low_pulse(500 * T);
      idle(T + 2);
      od_req = 1'b1;
      @(negedge clk);
      od_req = 1'b0;
      idle(800);
      chk(det_cnt == d0 + 1, "R8 reset accepted", det_cnt - d0, 1);
      chk(od_mode == 0, "R8 request in decision clock dropped", od_mode, 0);

      cur_req = "R10";
      d0 = det_cnt;
      p0 = pd_cnt;
      low_pulse(480 * T);
      idle(20);
      low_pulse(40);
      idle(1000);
      chk(det_cnt == d0 + 1, "R10 no reset from wait activity or own pulse", det_cnt - d0, 1);
      chk(pd_cnt == p0 + 1, "R10 one presence pulse", pd_cnt - p0, 1);

      chk(det_double == 0, "R5 strobe longer than one clock", det_double, 0);
      finish_run();
   end

endmodule